// File: doc/BRIEF.md
# Audio Block-Complete Interrupt Counter

This block sits between the host register interface of an audio codec and its converter timing. The host programs a 16-bit block length, expressed as sample frames per block minus one, through two indirect byte registers, then turns on playback, capture or both through a run-control register. From then on every frame strobe from the converter side takes one off a down-counter. When a strobe arrives with the counter at zero, the block is complete. The counter reloads itself from the programmed length and a sticky pending flag is raised. That flag drives the interrupt line until the host writes the status port.

Because the reload is automatic, a driver feeding back-to-back buffers of the same size programs the length once. The block also reports the byte size of one block for the format currently selected in the format register. This lets the DMA side size its transfers from the same programmed value: 8-bit and companded data use one byte per mono frame, 16-bit data two, ADPCM four, and stereo doubles each.

Top module: `sample_block_irq`

## Requirements
- R1: After a synchronous active-low reset, cur_count is 0, irq and status_pending are 0, play_active and cap_active are 0, and the programmed length is 0 (block_bytes reads 1).
- R2: An indirect write to index 15 sets the low byte of the block length and one to index 14 sets the high byte; writes to any other index leave the length unchanged.
- R3: On the clock edge after a run-control bit (index 9, bit 0 playback, bit 1 capture) goes from 0 to 1, cur_count is loaded with the programmed length, whatever frame strobe is present on that edge.
- R4: While either run-control bit is set, each frame strobe lowers cur_count by one; a strobe with cur_count at 0 reloads cur_count from the programmed length and sets the pending flag, so one block is length+1 strobes.
- R5: With index 9 bits 1:0 both 0, frame strobes have no effect: cur_count and the pending flag hold.
- R6: A status-port write clears the pending flag on the next edge; if a block completes on the same edge, the flag stays set.
- R7: irq and status_pending both show the pending flag.
- R8: play_active equals index 9 bit 0 and cap_active equals index 9 bit 1; writing 0 to index 9 stops both directions.
- R9: block_bytes equals (length+1) shifted left by k, where the format code in index 8 bits 7:5 gives k=0 for codes 0 (unsigned 8-bit), 1 (mu-law), 3 (A-law) and the unused codes 4 and 7, k=1 for codes 2 and 6 (16-bit), and k=2 for code 5 (ADPCM); index 8 bit 4 (stereo) adds 1 to k, and bits 3:0 have no effect.
- R10: A change of the programmed length while running leaves cur_count alone; the new length takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Indirect register write strobe |
| reg_idx | input | 5 | Indirect register index |
| reg_wdata | input | 8 | Indirect register write data |
| stat_wr | input | 1 | Status-port write, clears the pending flag |
| frame_stb | input | 1 | One-cycle pulse per transferred sample frame |
| irq | output | 1 | Interrupt request, high while a block completion is pending |
| status_pending | output | 1 | Status bit 0, block completion pending |
| play_active | output | 1 | Playback direction enabled |
| cap_active | output | 1 | Capture direction enabled |
| cur_count | output | 16 | Frames left in the current block, minus one |
| block_bytes | output | 20 | Bytes per block for the selected format |

## Verification
The byte-size path is driven with a table of lengths crossed with every format code, mono and stereo, including the full-scale length and clock-select bits set. This separates the shift chosen for each code and shows the stereo doubling and the carry out of the top length bit. The counting path is run with small lengths so each strobe can be checked. These runs tell apart load on enable, decrement, the wrap that reloads and flags, a halt that freezes the count, a length change mid-block that only appears at the next wrap, and a clear colliding with a completion.

// File: rtl/sbi_pkg.sv
// Package: shared format codes and the byte-shift rule for the
// block-complete interrupt counter. Assumes 3-bit format codes.
package sbi_pkg;

    typedef enum logic [2:0] {
        FMT_U8    = 3'd0,
        FMT_ULAW  = 3'd1,
        FMT_S16L  = 3'd2,
        FMT_ALAW  = 3'd3,
        FMT_RSV4  = 3'd4,
        FMT_ADPCM = 3'd5,
        FMT_S16B  = 3'd6,
        FMT_RSV7  = 3'd7
    } fmt_code_e;

    // Left shift from frames to bytes for one block.
    function automatic logic [1:0] bytes_shift(input fmt_code_e code, input logic stereo);
        logic [1:0] base_k;
        case (code)
            FMT_S16L, FMT_S16B: base_k = 2'd1;
            FMT_ADPCM:          base_k = 2'd2;
            default:            base_k = 2'd0;
        endcase
        return base_k + {1'b0, stereo};
    endfunction

endpackage

// File: rtl/sbi_regs.sv
// Indirect register file: block length bytes, run control and format.
// Assumes one write per cycle; every register resets to zero.
module sbi_regs #(
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned IDX_LO   = 15,
    parameter int unsigned IDX_HI   = 14,
    parameter int unsigned IDX_RUN  = 9,
    parameter int unsigned IDX_FMT  = 8,
    localparam int unsigned LEN_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [LEN_W-1:0]  length,
    output logic [1:0]        run_en,
    output sbi_pkg::fmt_code_e fmt_code,
    output logic              stereo
);
    import sbi_pkg::*;

    // One byte lane per half of the block length.
    for (genvar b = 0; b < 2; b++) begin : g_lane
        localparam int unsigned LANE_IDX = (b == 0) ? IDX_LO : IDX_HI;
        logic [DATA_W-1:0] lane_q;

        // Capture the byte written to this lane's index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (wr && idx == ADDR_W'(LANE_IDX))
                lane_q <= wdata;
        end

        assign length[b*DATA_W +: DATA_W] = lane_q;
    end

    // Run control: bit 0 playback, bit 1 capture.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_en <= 2'b00;
        else if (wr && idx == ADDR_W'(IDX_RUN))
            run_en <= wdata[1:0];
    end

    // Format: keep only the code and stereo bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_code <= FMT_U8;
            stereo   <= 1'b0;
        end else if (wr && idx == ADDR_W'(IDX_FMT)) begin
            fmt_code <= fmt_code_e'(wdata[7:5]);
            stereo   <= wdata[4];
        end
    end

endmodule

// File: rtl/sbi_counter.sv
// Frame down-counter with load on enable rise and reload on wrap.
// Assumes frame_stb is a single-cycle pulse per frame.
module sbi_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       run_en,
    input  logic [CNT_W-1:0] length,
    input  logic             frame_stb,
    output logic [CNT_W-1:0] count,
    output logic             load_pulse,
    output logic             wrap
);
    logic [1:0] run_en_d;
    logic       running;

    assign running    = |run_en;
    assign load_pulse = |(run_en & ~run_en_d);
    assign wrap       = running && frame_stb && !load_pulse && count == '0;

    // Remember the previous run bits to find a rising bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_en_d <= 2'b00;
        else
            run_en_d <= run_en;
    end

    // Load, reload or decrement the frame count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load_pulse || wrap)
            count <= length;
        else if (running && frame_stb)
            count <= count - CNT_W'(1);
    end

endmodule

// File: rtl/sbi_flag.sv
// Sticky block-complete flag; set has priority over clear.
// Assumes clr is a status-port write pulse.
module sbi_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the pending flag until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

endmodule

// File: rtl/sbi_size.sv
// Combinational block byte size from length and format.
// Assumes the result width leaves room for length+1 shifted by 3.
module sbi_size #(
    parameter int unsigned CNT_W   = 16,
    localparam int unsigned BYTES_W = CNT_W + 4
) (
    input  logic [CNT_W-1:0]   length,
    input  sbi_pkg::fmt_code_e fmt_code,
    input  logic               stereo,
    output logic [BYTES_W-1:0] bytes
);
    import sbi_pkg::*;

    logic [BYTES_W-1:0] frames;
    logic [1:0]         k;

    // Frames per block, then scale to bytes.
    always_comb begin
        frames = {{(BYTES_W-CNT_W){1'b0}}, length} + BYTES_W'(1);
        k      = bytes_shift(fmt_code, stereo);
        bytes  = frames << k;
    end

endmodule

// File: rtl/sample_block_irq.sv
// Top: block-complete interrupt counter for audio DMA blocks.
// Assumes a single clock domain and synchronous active-low reset.
module sample_block_irq #(
    parameter int unsigned ADDR_W  = 5,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned IDX_LO  = 15,
    parameter int unsigned IDX_HI  = 14,
    parameter int unsigned IDX_RUN = 9,
    parameter int unsigned IDX_FMT = 8,
    localparam int unsigned CNT_W   = 2 * DATA_W,
    localparam int unsigned BYTES_W = CNT_W + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               stat_wr,
    input  logic               frame_stb,
    output logic               irq,
    output logic               status_pending,
    output logic               play_active,
    output logic               cap_active,
    output logic [CNT_W-1:0]   cur_count,
    output logic [BYTES_W-1:0] block_bytes
);
    import sbi_pkg::*;

    logic [CNT_W-1:0] base_q;
    logic [1:0]       run_en;
    fmt_code_e        fmt_code;
    logic             stereo;
    logic             load_pulse;
    logic             wrap;
    logic             pend;

    sbi_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_LO(IDX_LO),
        .IDX_HI(IDX_HI), .IDX_RUN(IDX_RUN), .IDX_FMT(IDX_FMT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .idx(reg_idx),
        .wdata(reg_wdata), .length(base_q), .run_en(run_en),
        .fmt_code(fmt_code), .stereo(stereo)
    );

    sbi_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .length(base_q),
        .frame_stb(frame_stb), .count(cur_count),
        .load_pulse(load_pulse), .wrap(wrap)
    );

    sbi_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(wrap), .clr(stat_wr), .flag(pend)
    );

    sbi_size #(.CNT_W(CNT_W)) u_size (
        .length(base_q), .fmt_code(fmt_code), .stereo(stereo),
        .bytes(block_bytes)
    );

    assign irq            = pend;
    assign status_pending = pend;
    assign play_active    = run_en[0];
    assign cap_active     = run_en[1];

endmodule

// File: rtl/sample_block_irq_chk.sv
// Checker for the block-complete interrupt counter, bound to the top.
module sample_block_irq_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stat_wr,
    input logic             frame_stb,
    input logic             irq,
    input logic             play_active,
    input logic             cap_active,
    input logic [CNT_W-1:0] cur_count,
    input logic [CNT_W-1:0] base_q,
    input logic             load_pulse,
    input logic             wrap
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (cur_count == '0 && !irq && !play_active && !cap_active));

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> cur_count == $past(base_q));

    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && (play_active || cap_active) && !load_pulse && cur_count != '0)
        |=> cur_count == $past(cur_count) - CNT_W'(1));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (irq && cur_count == $past(base_q)));

    p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!play_active && !cap_active) |=> ($stable(cur_count) && $stable(irq)));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !wrap) |=> !irq);

endmodule

bind sample_block_irq sample_block_irq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .frame_stb(frame_stb),
    .irq(irq), .play_active(play_active), .cap_active(cap_active),
    .cur_count(cur_count), .base_q(base_q), .load_pulse(load_pulse),
    .wrap(wrap)
);

// File: tb/test_sample_block_irq.sv
module test_sample_block_irq;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // {length[15:0], format byte[7:0], expected bytes[19:0]}
    localparam logic [43:0] VEC [NVEC] = '{
        {16'h0003, 8'h00, 20'h00004},
        {16'h0003, 8'h10, 20'h00008},
        {16'h00FF, 8'h40, 20'h00200},
        {16'h00FF, 8'h50, 20'h00400},
        {16'h0001, 8'hA0, 20'h00008},
        {16'h0001, 8'hB0, 20'h00010},
        {16'h1234, 8'h20, 20'h01235},
        {16'h1234, 8'hC0, 20'h0246A},
        {16'hFFFF, 8'hB0, 20'h80000},
        {16'h0002, 8'h60, 20'h00003},
        {16'h0002, 8'h80, 20'h00003},
        {16'h0002, 8'h0F, 20'h00003}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [7:0]  reg_wdata = '0;
    logic        stat_wr = 1'b0;
    logic        frame_stb = 1'b0;
    logic        irq, status_pending, play_active, cap_active;
    logic [15:0] cur_count;
    logic [19:0] block_bytes;

    int checks = 0;
    int fails = 0;

    sample_block_irq i_sample_block_irq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .stat_wr(stat_wr), .frame_stb(frame_stb),
        .irq(irq), .status_pending(status_pending),
        .play_active(play_active), .cap_active(cap_active),
        .cur_count(cur_count), .block_bytes(block_bytes)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] i, input logic [7:0] d);
        reg_wr = 1'b1; reg_idx = i; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic stb(input int n);
        for (int s = 0; s < n; s++) begin
            frame_stb = 1'b1;
            @(negedge clk);
            frame_stb = 1'b0;
        end
    endtask

    task automatic clr();
        stat_wr = 1'b1;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    task automatic set_len(input logic [15:0] v);
        wr(5'd15, v[7:0]);
        wr(5'd14, v[15:8]);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        // R1 reset state
        check(cur_count == 0, "R1 count", 32'(cur_count), 0);
        check(!irq && !status_pending, "R1 irq", 32'(irq), 0);
        check(!play_active && !cap_active, "R1 run", {30'd0, cap_active, play_active}, 0);
        check(block_bytes == 20'd1, "R1 bytes", 32'(block_bytes), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R9 table walk
        for (int v = 0; v < NVEC; v++) begin
            set_len(VEC[v][43:28]);
            wr(5'd8, VEC[v][27:20]);
            check(block_bytes == VEC[v][19:0], "R9 R2 table",
                  32'(block_bytes), 32'(VEC[v][19:0]));
        end

        // R2 other indices leave the length alone
        wr(5'd13, 8'hFF);
        wr(5'd16, 8'hFF);
        check(block_bytes == 20'd3, "R2 other index", 32'(block_bytes), 3);

        // R3 / R8 playback start loads the count
        wr(5'd8, 8'h00);
        set_len(16'd3);
        wr(5'd9, 8'h0D);
        check(play_active && !cap_active, "R8 play", {30'd0, cap_active, play_active}, 1);
        @(negedge clk);
        check(cur_count == 3, "R3 load", 32'(cur_count), 3);

        // R4 decrement and wrap
        stb(3);
        check(cur_count == 0 && !irq, "R4 decrement", 32'(cur_count), 0);
        stb(1);
        check(irq == 1'b1, "R4 flag", 32'(irq), 1);
        check(cur_count == 3, "R4 reload", 32'(cur_count), 3);
        check(status_pending == irq, "R7 status", 32'(status_pending), 32'(irq));

        // R6 clear
        clr();
        check(!irq && !status_pending, "R6 clear", 32'(irq), 0);

        // R10 length change mid-block
        stb(1);
        set_len(16'd5);
        check(cur_count == 2, "R10 hold", 32'(cur_count), 2);
        stb(3);
        check(cur_count == 5 && irq, "R10 reload new", 32'(cur_count), 5);
        clr();

        // R5 halt
        stb(2);
        wr(5'd9, 8'h00);
        check(!play_active && !cap_active, "R8 halt", {30'd0, cap_active, play_active}, 0);
        stb(4);
        check(cur_count == 3, "R5 count holds", 32'(cur_count), 3);
        check(!irq, "R5 flag holds", 32'(irq), 0);

        // R3 capture start reloads, strobe on load edge ignored
        reg_wr = 1'b1; reg_idx = 5'd9; reg_wdata = 8'h0E;
        @(negedge clk);
        reg_wr = 1'b0;
        check(cap_active && !play_active, "R8 capture", {30'd0, cap_active, play_active}, 2);
        stb(1);
        check(cur_count == 5, "R3 capture load", 32'(cur_count), 5);

        // R6 clear collides with completion
        stb(5);
        stb(1);
        check(irq && cur_count == 5, "R4 capture wrap", 32'(cur_count), 5);
        stb(5);
        stat_wr = 1'b1; frame_stb = 1'b1;
        @(negedge clk);
        stat_wr = 1'b0; frame_stb = 1'b0;
        check(irq == 1'b1, "R6 set wins", 32'(irq), 1);
        check(cur_count == 5, "R4 second wrap", 32'(cur_count), 5);
        clr();
        check(!irq, "R6 clear after", 32'(irq), 0);

        // R1 reset mid-run
        stb(2);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(cur_count == 0 && !cap_active, "R1 mid-run reset", 32'(cur_count), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule